// File: doc/BRIEF.md
# Horizontal Sync Regenerator with Format Classifier

This block sits behind the comparators of an analog video front end. It receives two sampled bits: `sync_lo`, high while the input sits below the sync slice level, and `sync_hi`, high while the input sits above the positive threshold of a tri-level sync. From these bits it times the line period and looks at the sync shape. It then sorts the input into standard definition, enhanced definition, high definition with tri-level sync, or an unknown bi-level rate such as PC graphics timing.

Once a class is committed, the block regenerates a clean, active-low horizontal sync pulse for each line. The pulse width is fixed per class and set in clock cycles by parameters. The block also drives an active-low HD flag, which can switch an external chroma filter out of the path. Format changes are followed without a reset. A dropout unlocks the block, and it then learns the new line rate from scratch. Clamping and slicing happen outside this block.

Top module: `hsync_regen`

## Requirements
- R1: `hsync_n` is active low. For a bi-level class its falling edge follows the rising edge of `sync_lo` (two clock edges later). For the HD class it follows the falling edge of `sync_lo` at the negative-to-positive crossing. While the negative half of a tri-level sync is still present, `hsync_n` stays high.
- R2: Each pulse is low for exactly `W_SD`, `W_ED`, `W_HD` or `W_UNK` clock cycles, according to the committed class.
- R3: `fmt` reports the committed class: 1 for SD (period at least `SD_MIN`), 2 for ED (period at least `ED_MIN`), 3 for HD (tri-level sync seen), and 0 when unlocked or for a bi-level period below `ED_MIN`.
- R4: `hd_n` is low only while locked to tri-level sync. Bi-level input of any rate, including short PC-style periods, leaves it high.
- R5: A class is committed only after `LOCK_N` consecutive line periods (default 8) agree within 2% and share the same sync shape. Before that, `hsync_n` and `hd_n` are high and `fmt` is 0.
- R6: While locked, a `sync_lo` rising edge less than 40% of the locked period after the last accepted edge is ignored: it starts no pulse and does not restart the period count.
- R7: If no edge is accepted for 4 locked periods, the block unlocks. `fmt` returns to 0, `hd_n` goes high and `hsync_n` is held high.
- R8: During a long sync-low interval with no serrations, no horizontal pulse is emitted and the lock is kept, provided the interval is shorter than the timeout.
- R9: After a format change, the block locks to the new format with no reset.
- R10: A synchronous active-high `rst` forces `hsync_n` and `hd_n` high and `fmt` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_lo | input | 1 | High while the input is below the sync slice level |
| sync_hi | input | 1 | High while the input is above the positive tri-level threshold |
| hsync_n | output | 1 | Regenerated horizontal sync, active low |
| hd_n | output | 1 | Tri-level HD detected, active low |
| fmt | output | 2 | Committed class: 0 none or unknown, 1 SD, 2 ED, 3 HD |

## Verification
Two functions can fall in the same cycle. A class commit or re-commit happens on the same accepted edge that may also start a pulse, and the serration gate and the timeout both act on the count since that edge. The bench provokes the overlap by switching line rate with no reset in between, so the old lock's gate and the new edges interact. It then judges the outcome by the width and count of the last pulses and by the reported class. A separate run lets the timeout expire on a locked HD input, and the bench then checks that the flag, the class and the sync output all fall back together.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
  typedef enum logic [1:0] {
    FMT_NONE = 2'd0,
    FMT_SD   = 2'd1,
    FMT_ED   = 2'd2,
    FMT_HD   = 2'd3
  } fmt_e;

  // Sync shape first, then line period against the two thresholds.
  function automatic fmt_e classify(input int per, input logic tri_l,
                                    input int sd_min, input int ed_min);
    if (tri_l) return FMT_HD;
    if (per >= sd_min) return FMT_SD;
    if (per >= ed_min) return FMT_ED;
    return FMT_NONE;
  endfunction
endpackage

// File: rtl/hsr_line_meter.sv
module hsr_line_meter #(
  parameter int CW      = 14,
  parameter int TRI_WIN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_lo,
  input  logic          sync_hi,
  input  logic          locked,
  input  logic [CW-1:0] gate,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] meas,
  output logic          acc,
  output logic          lo_fall,
  output logic          line_tri
);
  localparam int TWW = $clog2(TRI_WIN + 1);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic lo_q, lo_qq, hi_q, tri_seen, lo_rise;
  logic [TWW-1:0] tw;

  assign lo_rise  = lo_q & ~lo_qq;
  assign lo_fall  = ~lo_q & lo_qq;
  // Edges too close to the previous accepted one are serrations.
  assign acc      = lo_rise && !(locked && cnt < gate);
  assign meas     = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign line_tri = tri_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= 1'b0; lo_qq <= 1'b0; hi_q <= 1'b0;
      cnt <= '0; tw <= '0; tri_seen <= 1'b0;
    end else begin
      lo_q  <= sync_lo;
      lo_qq <= lo_q;
      hi_q  <= sync_hi;
      if (acc) cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (lo_fall) tw <= TWW'(TRI_WIN);
      else if (tw != 0) tw <= tw - 1'b1;
      if (acc) tri_seen <= 1'b0;
      else if (hi_q && tw != 0) tri_seen <= 1'b1;
    end
  end

  // R1: an accepted edge always comes from a sync_lo that was high
  a_r1_edge_from_input: assert property (@(posedge clk) disable iff (rst)
    acc |-> $past(sync_lo));
endmodule

// File: rtl/hsr_classifier.sv
module hsr_classifier
  import hsr_pkg::*;
#(
  parameter int CW     = 14,
  parameter int LOCK_N = 8,
  parameter int SD_MIN = 1400,
  parameter int ED_MIN = 700
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic [CW-1:0] meas,
  input  logic          line_tri,
  input  logic [CW-1:0] cnt,
  output logic          locked,
  output fmt_e          cls,
  output logic [CW-1:0] gate
);
  localparam int SW = (LOCK_N > 2) ? $clog2(LOCK_N) : 1;

  logic [CW-1:0] ref_per, lock_per, diff;
  logic [CW+5:0] diff_x50;
  logic [CW:0]   dbl;
  logic          ref_tri, agree, timeout;
  logic [SW-1:0] streak;

  always_comb begin
    diff     = (meas > ref_per) ? meas - ref_per : ref_per - meas;
    diff_x50 = {6'd0, diff} * (CW+6)'(50);
    agree    = (ref_per != 0) && (line_tri == ref_tri) &&
               (diff_x50 <= (CW+6)'(ref_per));
    timeout  = locked && ({2'b00, cnt} >= {lock_per, 2'b00});
    dbl      = {meas, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0; cls <= FMT_NONE; gate <= '0; lock_per <= '0;
      ref_per <= '0; ref_tri <= 1'b0; streak <= '0;
    end else if (timeout) begin
      locked <= 1'b0; cls <= FMT_NONE; ref_per <= '0; streak <= '0;
    end else if (acc) begin
      if (!agree) begin
        ref_per <= meas;
        ref_tri <= line_tri;
        streak  <= '0;
      end else if (streak == SW'(LOCK_N - 2)) begin
        locked   <= 1'b1;
        cls      <= classify(int'(meas), line_tri, SD_MIN, ED_MIN);
        lock_per <= meas;
        gate     <= CW'(dbl / (CW+1)'(5));
      end else begin
        streak <= streak + 1'b1;
      end
    end
  end

  // R5: a commit only ever happens on an accepted edge
  a_r5_lock_on_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(acc));
  // R7: a locked block that sees no edge for four periods lets go
  a_r7_timeout_drop: assert property (@(posedge clk) disable iff (rst)
    (locked && ({2'b00, cnt} >= {lock_per, 2'b00})) |=> !locked);
endmodule

// File: rtl/hsr_pulse_gen.sv
module hsr_pulse_gen
  import hsr_pkg::*;
#(
  parameter int W_SD  = 68,
  parameter int W_ED  = 62,
  parameter int W_HD  = 14,
  parameter int W_UNK = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic acc,
  input  logic lo_fall,
  input  logic locked,
  input  fmt_e cls,
  output logic hsync_n
);
  localparam int WA   = (W_SD > W_ED) ? W_SD : W_ED;
  localparam int WB   = (W_HD > W_UNK) ? W_HD : W_UNK;
  localparam int WMAX = (WA > WB) ? WA : WB;
  localparam int WW   = $clog2(WMAX + 1);

  logic [WW-1:0] hcnt, wsel;
  logic armed, start;

  always_comb begin
    case (cls)
      FMT_SD:  wsel = WW'(W_SD);
      FMT_ED:  wsel = WW'(W_ED);
      FMT_HD:  wsel = WW'(W_HD);
      default: wsel = WW'(W_UNK);
    endcase
    // Bi-level: leading edge. Tri-level: end of the negative half.
    start = locked && (((cls != FMT_HD) && acc) ||
                       ((cls == FMT_HD) && lo_fall && armed));
  end

  always_ff @(posedge clk) begin
    if (rst || !locked) begin
      hcnt <= '0; hsync_n <= 1'b1; armed <= 1'b0;
    end else begin
      if (acc) armed <= 1'b1;
      else if (lo_fall) armed <= 1'b0;
      if (start) begin
        hcnt <= wsel - WW'(1); hsync_n <= 1'b0;
      end else if (hcnt != 0) begin
        hcnt <= hcnt - 1'b1; hsync_n <= 1'b0;
      end else begin
        hsync_n <= 1'b1;
      end
    end
  end

  // R5: no pulse begins unless a class was committed
  a_r5_fall_needs_lock: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> $past(locked));
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen
  import hsr_pkg::*;
#(
  parameter int PER_W   = 12,
  parameter int LOCK_N  = 8,
  parameter int SD_MIN  = 1400,
  parameter int ED_MIN  = 700,
  parameter int TRI_WIN = 32,
  parameter int W_SD    = 68,
  parameter int W_ED    = 62,
  parameter int W_HD    = 14,
  parameter int W_UNK   = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_lo,
  input  logic       sync_hi,
  output logic       hsync_n,
  output logic       hd_n,
  output logic [1:0] fmt
);
  localparam int CW = PER_W + 2;

  logic [CW-1:0] cnt, meas, gate;
  logic acc, lo_fall, line_tri, locked;
  fmt_e cls, fmt_q;

  hsr_line_meter #(.CW(CW), .TRI_WIN(TRI_WIN)) u_meter (
    .clk(clk), .rst(rst), .sync_lo(sync_lo), .sync_hi(sync_hi),
    .locked(locked), .gate(gate), .cnt(cnt), .meas(meas),
    .acc(acc), .lo_fall(lo_fall), .line_tri(line_tri));

  hsr_classifier #(.CW(CW), .LOCK_N(LOCK_N), .SD_MIN(SD_MIN),
                   .ED_MIN(ED_MIN)) u_class (
    .clk(clk), .rst(rst), .acc(acc), .meas(meas), .line_tri(line_tri),
    .cnt(cnt), .locked(locked), .cls(cls), .gate(gate));

  hsr_pulse_gen #(.W_SD(W_SD), .W_ED(W_ED), .W_HD(W_HD),
                  .W_UNK(W_UNK)) u_pulse (
    .clk(clk), .rst(rst), .acc(acc), .lo_fall(lo_fall),
    .locked(locked), .cls(cls), .hsync_n(hsync_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q <= FMT_NONE; hd_n <= 1'b1;
    end else begin
      fmt_q <= locked ? cls : FMT_NONE;
      hd_n  <= !(locked && cls == FMT_HD);
    end
  end
  assign fmt = fmt_q;

  // R4: the flag only drops alongside an HD class report
  a_r4_flag_means_hd: assert property (@(posedge clk) disable iff (rst)
    !hd_n |-> (fmt == 2'(FMT_HD)));
endmodule

// File: tb/hsync_regen_test.sv
`timescale 1ns/1ps
module hsync_regen_test;
  logic clk = 1'b0, rst, sync_lo, sync_hi;
  logic hsync_n, hd_n;
  logic [1:0] fmt;
  int n_chk = 0, n_err = 0;
  int npulse = 0, cur = 0, last_w = 0, p0;
  logic prev = 1'b1;

  // columns: period, sync low length, tri-level, fmt, hd_n, pulse width
  localparam int TBL [5][6] = '{
    '{200, 30, 0, 1, 1, 20},
    '{100, 15, 0, 2, 1, 16},
    '{ 60,  5, 1, 3, 0,  6},
    '{ 40,  6, 0, 0, 1,  8},
    '{200, 30, 0, 1, 1, 20}};

  always #2.5 clk = ~clk;

  hsync_regen #(.PER_W(12), .LOCK_N(8), .SD_MIN(160), .ED_MIN(80),
                .TRI_WIN(8), .W_SD(20), .W_ED(16), .W_HD(6), .W_UNK(8)) uut (
    .clk(clk), .rst(rst), .sync_lo(sync_lo), .sync_hi(sync_hi),
    .hsync_n(hsync_n), .hd_n(hd_n), .fmt(fmt));

  always @(negedge clk) begin
    if (rst) begin
      cur = 0; prev = 1'b1;
    end else begin
      if (!hsync_n) cur++;
      if (hsync_n && !prev) begin last_w = cur; npulse++; cur = 0; end
      prev = hsync_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_line(input int per, input int low, input int trl);
    sync_lo = 1'b1; sync_hi = 1'b0;
    repeat (low) @(negedge clk);
    sync_lo = 1'b0; sync_hi = (trl != 0);
    repeat ((trl != 0) ? low : 0) @(negedge clk);
    sync_hi = 1'b0;
    repeat (per - low - ((trl != 0) ? low : 0)) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; sync_lo = 1'b0; sync_hi = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 reset hsync_n", int'(hsync_n), 1);
    chk("R10 reset hd_n", int'(hd_n), 1);
    chk("R10 reset fmt", int'(fmt), 0);
    rst = 1'b0;
    @(negedge clk);

    // R5: too few agreeing lines, nothing committed
    p0 = npulse;
    repeat (5) drive_line(200, 30, 0);
    chk("R5 pre-lock fmt", int'(fmt), 0);
    chk("R5 pre-lock pulses", npulse - p0, 0);
    chk("R5 pre-lock hd_n", int'(hd_n), 1);

    // R2 R3 R4 R9: table walk, formats change with no reset between
    for (int e = 0; e < 5; e++) begin
      for (int l = 0; l < 20; l++) drive_line(TBL[e][0], TBL[e][1], TBL[e][2]);
      p0 = npulse;
      for (int l = 0; l < 4; l++) drive_line(TBL[e][0], TBL[e][1], TBL[e][2]);
      chk("R3 class", int'(fmt), TBL[e][3]);
      chk("R4 hd flag", int'(hd_n), TBL[e][4]);
      chk("R2 pulse width", last_w, TBL[e][5]);
      chk("R9 pulses per line", npulse - p0, 4);
    end

    // R1: bi-level pulse follows the sync_lo rise
    sync_lo = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 SD leading edge", int'(hsync_n), 0);
    repeat (27) @(negedge clk);
    sync_lo = 1'b0;
    repeat (170) @(negedge clk);

    // R6: extra pulse 60 cycles in (30% of 200) is ignored
    p0 = npulse;
    for (int l = 0; l < 4; l++) begin
      sync_lo = 1'b1; repeat (30) @(negedge clk);
      sync_lo = 1'b0; repeat (30) @(negedge clk);
      sync_lo = 1'b1; repeat (10) @(negedge clk);
      sync_lo = 1'b0; repeat (130) @(negedge clk);
    end
    chk("R6 serration pulses", npulse - p0, 4);
    chk("R6 class kept", int'(fmt), 1);
    chk("R6 width kept", last_w, 20);

    // R8: broad low of 500 cycles, no serrations
    drive_line(200, 30, 0);
    sync_lo = 1'b1;
    repeat (40) @(negedge clk);
    p0 = npulse;
    repeat (460) @(negedge clk);
    chk("R8 no pulse in vertical", npulse - p0, 0);
    sync_lo = 1'b0;
    repeat (100) @(negedge clk);
    chk("R8 lock kept", int'(fmt), 1);
    repeat (2) drive_line(200, 30, 0);

    // R9: switch to tri-level HD
    repeat (24) drive_line(60, 5, 1);
    chk("R9 relock HD", int'(fmt), 3);

    // R1: HD pulse waits for the end of the negative half
    sync_lo = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 HD high in negative half", int'(hsync_n), 1);
    repeat (2) @(negedge clk);
    sync_lo = 1'b0; sync_hi = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 HD at mid crossing", int'(hsync_n), 0);
    repeat (2) @(negedge clk);
    sync_hi = 1'b0;
    repeat (50) @(negedge clk);

    // R7: sync disappears for 5 HD periods
    p0 = npulse;
    repeat (300) @(negedge clk);
    chk("R7 timeout fmt", int'(fmt), 0);
    chk("R7 timeout hd_n", int'(hd_n), 1);
    chk("R7 timeout hsync_n", int'(hsync_n), 1);
    chk("R7 no pulses", npulse - p0, 0);

    // R10: reset while locked to HD
    repeat (24) drive_line(60, 5, 1);
    chk("R4 HD flag low", int'(hd_n), 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 reset hd_n", int'(hd_n), 1);
    chk("R10 reset fmt", int'(fmt), 0);
    chk("R10 reset hsync_n", int'(hsync_n), 1);
    rst = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule